// File: doc/BRIEF.md
# Four-Slot Ring Receive Buffer

This block sits between a serial receiver and software. Each time the receiver finishes a byte, it presents a one-cycle valid strobe with the byte and three status bits: parity error, multiprocessor marker and framing error. In ring mode, the block places each byte in the next of four slots in rotation. Software can then let up to four bytes build up and handle them together. With ring mode clear, the block acts as a single receive buffer in which slot 0 is always written.

A small state machine holds the write pointer. Its states are SLOT0, SLOT1, SLOT2 and SLOT3. It has three transitions:
- ADVANCE: a store in ring mode moves to the next state, and SLOT3 goes to SLOT0.
- HOLD: with no store, the state stays put.
- FORCE_ZERO: while ring mode is clear, the next state is SLOT0.

Servicing the data never moves the pointer. Software picks the slots that raise a receive-complete request by setting one enable bit per slot. For a burst of m bytes, it enables only the slot that the last of them will land in.

Register port (3-bit address, bit 0 of a field is the LSB):
- 0 control: bit0 ring mode, bits 7:4 slot interrupt enables.
- 1 status: bits 1:0 next slot, bit2 sticky framing flag (write 1 clears), bit3 shared request (read only), bits 7:4 slot request flags (write 1 clears).
- 2 to 5: data of slots 0 to 3. A read with the consume strobe clears that slot's unread bit.
- 6: bits 3:0 slot parity flags (write 1 clears), bits 7:4 slot multiprocessor bits.
- 7: bits 3:0 slot overrun flags (write 1 clears), bits 7:4 slot unread bits (read only).

Read data is combinational from the address.

Top module: `rx_ring_buffer`

## Requirements
- R1: With control bit0 clear, every byte is stored in slot 0, and the pointer field reads 0 from the cycle after the clear takes effect.
- R2: With control bit0 set, successive bytes go to slots 0, 1, 2, 3, 0 and so on, continuing from wherever the pointer stands.
- R3: Status bits 1:0 always show the slot that will take the next byte. Reads and flag clears do not change them.
- R4: A slot request flag (status bit 4+k) sets only when a byte is stored into slot k while enable bit 4+k of control is set.
- R5: The irq output, and status bit3, are high whenever any slot request flag is set.
- R6: Each store loads that slot's parity flag and multiprocessor bit from the byte's status, alongside its data.
- R7: Status bit2 sets when any stored byte carries a framing error and stays set until cleared by software.
- R8: When a byte is stored into a slot whose unread bit is set, the new byte overwrites it and the slot's overrun flag sets.
- R9: A store sets the slot's unread bit. A consuming read of that slot's data address clears it.
- R10: Writing 1 to a parity, overrun, framing or request flag bit clears it. Writing 0 leaves it. All flags, the pointer and the control bits reset to zero.
- R11: When a store and a consuming read hit the same slot in one cycle, the unread bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is ready |
| rx_data | input | 8 | Received byte |
| rx_parity_err | input | 1 | Parity error for this byte |
| rx_mp | input | 1 | Multiprocessor marker for this byte |
| rx_frame_err | input | 1 | Framing error for this byte |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Consume strobe for a data read |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Shared receive-complete request |

## Verification
The hardest states to reach are the ones that depend on where the pointer stands at the moment a burst begins. An overrun on a given slot, or a request from one particular slot within a burst, only occurs with the pointer in the right position.

The bench sweeps all sixteen enable masks. For each mask it stores five bytes, so the pointer moves on by one slot per mask and every starting slot meets every mask. The fifth byte of each run lands on an unread slot and forces an overrun.

The collision of a store with a consuming read is reached by driving the strobe and the read of the current pointer slot on the same edge.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int PTR_W     = $clog2(NUM_SLOTS);
    localparam int ADDR_W    = 3;

    typedef enum logic [PTR_W-1:0] {SLOT0, SLOT1, SLOT2, SLOT3} slot_e;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_D0   = 3'd2;
    localparam logic [ADDR_W-1:0] A_D1   = 3'd3;
    localparam logic [ADDR_W-1:0] A_D2   = 3'd4;
    localparam logic [ADDR_W-1:0] A_D3   = 3'd5;
    localparam logic [ADDR_W-1:0] A_PFLG = 3'd6;
    localparam logic [ADDR_W-1:0] A_OFLG = 3'd7;
endpackage

// File: rtl/rxr_ptr_fsm.sv
module rxr_ptr_fsm
    import rxr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ring_en,
    input  logic                 store,
    output logic [PTR_W-1:0]     ptr_o,
    output logic [NUM_SLOTS-1:0] sel_oh
);
    slot_e cur, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= SLOT0;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        if (!ring_en) begin
            nxt = SLOT0;                 // FORCE_ZERO
        end else if (store) begin
            unique case (cur)            // ADVANCE
                SLOT0: nxt = SLOT1;
                SLOT1: nxt = SLOT2;
                SLOT2: nxt = SLOT3;
                SLOT3: nxt = SLOT0;
            endcase
        end                              // otherwise HOLD
    end

    always_comb begin
        ptr_o  = cur;
        sel_oh = '0;
        unique case (cur)
            SLOT0: sel_oh[0] = 1'b1;
            SLOT1: sel_oh[1] = 1'b1;
            SLOT2: sel_oh[2] = 1'b1;
            SLOT3: sel_oh[3] = 1'b1;
        endcase
    end

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_en && store) |=> ptr_o == $past(ptr_o) + 2'd1);
    assert_single_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_en |=> ptr_o == '0);
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_en && !store) |=> $stable(ptr_o));
    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_oh) == 1);
endmodule

// File: rtl/rxr_slot.sv
module rxr_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              perr_i,
    input  logic              mp_i,
    input  logic              consume_i,
    input  logic              clr_perr_i,
    input  logic              clr_ovr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              unread_o,
    output logic              perr_o,
    output logic              mp_o,
    output logic              ovr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o   <= '0;
            unread_o <= 1'b0;
            perr_o   <= 1'b0;
            mp_o     <= 1'b0;
            ovr_o    <= 1'b0;
        end else begin
            if (store_i) begin
                data_o <= data_i;
                mp_o   <= mp_i;
            end
            if (store_i)        unread_o <= 1'b1;
            else if (consume_i) unread_o <= 1'b0;
            if (store_i)         perr_o <= perr_i;
            else if (clr_perr_i) perr_o <= 1'b0;
            if (store_i && unread_o) ovr_o <= 1'b1;
            else if (clr_ovr_i)      ovr_o <= 1'b0;
        end
    end

    assert_unread_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        store_i |=> unread_o);
    assert_unread_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && !store_i) |=> !unread_o);
    assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && unread_o) |=> ovr_o);
    assert_collide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && consume_i) |=> unread_o);
endmodule

// File: rtl/rx_ring_buffer.sv
module rx_ring_buffer
    import rxr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_parity_err,
    input  logic              rx_mp,
    input  logic              rx_frame_err,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic                 ring_q;
    logic [NUM_SLOTS-1:0] ie_q, req_q, sel_oh, store_sel;
    logic                 frame_q;
    logic [PTR_W-1:0]     ptr;
    logic [DATA_W-1:0]    slot_data [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] unread, perr, mp, ovr;
    logic [NUM_SLOTS-1:0] consume, req_set, req_clr;
    logic                 wr_ctrl, wr_stat, wr_pflg, wr_oflg;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign wr_pflg = wr_en && (addr == A_PFLG);
    assign wr_oflg = wr_en && (addr == A_OFLG);

    rxr_ptr_fsm u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ring_en (ring_q),
        .store   (rx_valid),
        .ptr_o   (ptr),
        .sel_oh  (sel_oh)
    );

    assign store_sel = ring_q ? sel_oh : NUM_SLOTS'(1);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign consume[k] = rd_en && (addr == A_D0 + ADDR_W'(k));
        assign req_set[k] = rx_valid && store_sel[k] && ie_q[k];
        assign req_clr[k] = wr_stat && wr_data[4+k];
        rxr_slot #(.DATA_W(DATA_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .store_i    (rx_valid && store_sel[k]),
            .data_i     (rx_data),
            .perr_i     (rx_parity_err),
            .mp_i       (rx_mp),
            .consume_i  (consume[k]),
            .clr_perr_i (wr_pflg && wr_data[k]),
            .clr_ovr_i  (wr_oflg && wr_data[k]),
            .data_o     (slot_data[k]),
            .unread_o   (unread[k]),
            .perr_o     (perr[k]),
            .mp_o       (mp[k]),
            .ovr_o      (ovr[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q  <= 1'b0;
            ie_q    <= '0;
            frame_q <= 1'b0;
            req_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ring_q <= wr_data[0];
                ie_q   <= wr_data[7:4];
            end
            if (rx_valid && rx_frame_err)  frame_q <= 1'b1;
            else if (wr_stat && wr_data[2]) frame_q <= 1'b0;
            req_q <= (req_q & ~req_clr) | req_set;
        end
    end

    assign irq = |req_q;

    always_comb begin
        rd_data = '0;
        case (addr)
            A_CTRL: rd_data = DATA_W'({ie_q, 3'b000, ring_q});
            A_STAT: rd_data = DATA_W'({req_q, irq, frame_q, ptr});
            A_D0:   rd_data = slot_data[0];
            A_D1:   rd_data = slot_data[1];
            A_D2:   rd_data = slot_data[2];
            A_D3:   rd_data = slot_data[3];
            A_PFLG: rd_data = DATA_W'({mp, perr});
            A_OFLG: rd_data = DATA_W'({unread, ovr});
            default: rd_data = '0;
        endcase
    end

    assert_req_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_q & ~$past(req_q)) != '0) |->
            ($past(rx_valid) && (((req_q & ~$past(req_q)) & ~$past(ie_q)) == '0)));
    assert_irq_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && ((store_sel & ie_q) != '0)) |=> irq);
    assert_frame_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_frame_err) |=> frame_q);
    assert_frame_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_q && !(wr_stat && wr_data[2])) |=> frame_q);
endmodule

// File: tb/tb_rx_ring_buffer.sv
module tb_rx_ring_buffer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_parity_err = 1'b0, rx_mp = 1'b0, rx_frame_err = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // bench model
    bit         m_ring;
    bit [3:0]   m_ie, m_req, m_unread, m_perr, m_mp, m_ovr;
    bit         m_frame;
    bit [1:0]   m_ptr;
    logic [7:0] m_data [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_ring_buffer dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_parity_err(rx_parity_err), .rx_mp(rx_mp), .rx_frame_err(rx_frame_err),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_reg(int a);
        case (a)
            0: return {m_ie, 3'b000, m_ring};
            1: return {m_req, |m_req, m_frame, m_ptr};
            2, 3, 4, 5: return m_data[a-2];
            6: return {m_mp, m_perr};
            default: return {m_unread, m_ovr};
        endcase
    endfunction

    // called just after a negedge; no strobes active
    task automatic check_all(string tag);
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a);
            #1;
            check(tag, $sformatf("reg%0d", a), rd_data, exp_reg(a));
        end
        check(tag, "irq", {7'b0, irq}, {7'b0, |m_req});
    endtask

    function automatic void model_store(logic [7:0] d, bit pe, bit mpb, bit fe);
        int k = m_ring ? int'(m_ptr) : 0;
        if (m_unread[k]) m_ovr[k] = 1'b1;
        m_data[k]   = d;
        m_perr[k]   = pe;
        m_mp[k]     = mpb;
        m_unread[k] = 1'b1;
        if (fe) m_frame = 1'b1;
        if (m_ie[k]) m_req[k] = 1'b1;
        m_ptr = m_ring ? m_ptr + 2'd1 : 2'd0;
    endfunction

    task automatic store(logic [7:0] d, bit pe, bit mpb, bit fe);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        rx_parity_err = pe; rx_mp = mpb; rx_frame_err = fe;
        @(negedge clk);
        rx_valid = 1'b0; rx_parity_err = 1'b0; rx_mp = 1'b0; rx_frame_err = 1'b0;
        model_store(d, pe, mpb, fe);
    endtask

    task automatic reg_write(int a, logic [7:0] w);
        @(negedge clk);
        addr = 3'(a); wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);   // pointer settles after a mode change
        case (a)
            0: begin m_ring = w[0]; m_ie = w[7:4]; if (!m_ring) m_ptr = 2'd0; end
            1: begin if (w[2]) m_frame = 1'b0; m_req &= ~w[7:4]; end
            6: m_perr &= ~w[3:0];
            7: m_ovr &= ~w[3:0];
            default: ;
        endcase
    endtask

    task automatic consume(int k);
        @(negedge clk);
        addr = 3'(2 + k); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        m_unread[k] = 1'b0;
    endtask

    task automatic clear_all();
        for (int k = 0; k < 4; k++) consume(k);
        reg_write(1, 8'hF4);
        reg_write(6, 8'h0F);
        reg_write(7, 8'h0F);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        m_ring = 0; m_ie = 0; m_req = 0; m_unread = 0; m_perr = 0;
        m_mp = 0; m_ovr = 0; m_frame = 0; m_ptr = 0;
        for (int k = 0; k < 4; k++) m_data[k] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10 reset");

        // R2 R3 R4 R5 R6 R7 R8: all enable masks, five bytes each,
        // starting slot moves by one per mask
        for (int mask = 0; mask < 16; mask++) begin
            reg_write(0, {4'(mask), 4'b0001});
            for (int j = 0; j < 5; j++) begin
                store(8'((mask * 37 + j * 11) ^ 8'h5A), j[0], j[1],
                      (mask == 5 && j == 2));
                check_all("R2/R3/R4/R5/R6/R7/R8/R9");
            end
            // R3: reads and clears leave the pointer in place
            clear_all();
            check_all("R3/R9/R10 after clear");
        end

        // R10: writing zeros clears nothing
        reg_write(0, 8'hF1);
        store(8'hC3, 1'b1, 1'b0, 1'b1);
        store(8'h3C, 1'b1, 1'b1, 1'b0);
        reg_write(1, 8'h00);
        reg_write(6, 8'h00);
        reg_write(7, 8'h00);
        check_all("R10 write zero");
        reg_write(1, 8'hF4);
        reg_write(6, 8'h0F);
        check_all("R10 write one");

        // R11: store and consuming read of the same slot together
        @(negedge clk);
        addr = 3'(2 + int'(m_ptr)); rd_en = 1'b1;
        rx_valid = 1'b1; rx_data = 8'hA7;
        @(negedge clk);
        rx_valid = 1'b0; rd_en = 1'b0;
        model_store(8'hA7, 1'b0, 1'b0, 1'b0);
        check_all("R11 collision");

        // R1: single buffer mode keeps to slot 0
        clear_all();
        reg_write(0, 8'h10);
        check_all("R1 enter single");
        for (int j = 0; j < 3; j++) begin
            store(8'(8'h80 + j), 1'b0, j[0], 1'b0);
            check_all("R1/R8 single");
        end
        consume(0);
        check_all("R1/R9 single consume");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule